// File: doc/BRIEF.md
# Serial Slave Front End for a Byte-Wide Memory Array

This block is the four-wire serial slave port of a small nonvolatile memory, with the storage modelled as a register array. Everything runs on one system clock. The serial clock, chip-select, serial input and write-protect lines are sampled on that clock, and their edges are detected from the sampled values. A host lowers chip-select and sends an 8-bit opcode, then an address byte, then data bytes, most significant bit first. The block answers on a serial output whose drive enable drops whenever the device is deselected.

A write needs a prior write-enable command. It is committed only when chip-select rises on a byte boundary. The commit starts a modelled internal write cycle whose length is set by a parameter. During that cycle a busy flag is set, and the write-protect line no longer has any effect. If write-protect drops while the transfer is still in progress, the pending write is cancelled. After reset the port ignores all traffic until it has seen chip-select fall.

Top module: `spi_mem_slave`

## Requirements
- R1: Opcode, address and data bits are captured MSB first on rising edges of `sck`. The opcode encodings are: 0x06 sets the write latch, 0x02 writes, 0x03 reads, and 0x05 reads status. The frame is opcode, then address, then data.
- R2: A read puts each data bit on `so` after a falling edge of `sck`, MSB first. It starts at the addressed byte, and the address then increments modulo the array depth for as long as bytes continue.
- R3: While `cs_n` is high, `so_en` is low.
- R4: After reset, traffic is ignored and `so_en` stays low until `cs_n` has gone from high to low. A `cs_n` that is already low at reset does not count.
- R5: A write sent without a prior write-latch command leaves the memory unchanged and does not set `busy`.
- R6: A committed write raises `busy` on the clock after `cs_n` is sampled high. `busy` stays high for WR_CYCLES clocks. The byte is stored as `busy` drops, and the write latch is cleared at the same point.
- R7: A write is cancelled if `wp_n` is sampled low in any clock while `cs_n` is low during the transfer, or in the clock where `cs_n` is first sampled high. A cancelled write leaves memory unchanged and does not raise `busy`.
- R8: `wp_n` going low after `busy` has risen has no effect on that write.
- R9: The status byte holds busy in bit 0 and the write latch in bit 1, with the other bits zero. It repeats for every byte clocked after the opcode.
- R10: When `cs_n` rises in the middle of a byte, the transfer is discarded and memory is unchanged.
- R11: `standby` is high exactly when `cs_n` is high and `busy` is low.
- R12: Write and write-latch commands issued while `busy` is high have no effect.
- R13: A write stores only its first data byte. Further data bytes in the same transfer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock, idles low |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Write protect, active low |
| so | output | 1 | Serial data out |
| so_en | output | 1 | Drive enable for `so`; low means high impedance |
| busy | output | 1 | Internal write cycle in progress |
| standby | output | 1 | Deselected with no internal write running |

## Verification
The write commit at the rising edge of chip-select and the write-protect cancel can land in the same clock. The bench provokes this by lowering `wp_n` in the very clock where `cs_n` goes high. It expects `busy` to stay low and the addressed byte to read back unchanged. It then repeats the write with `wp_n` dropping one clock later, when `busy` has already risen. In that case it expects the new byte to be stored, which confirms that the cancel window closes exactly as the internal cycle begins.

// File: rtl/sme_pkg.sv
package sme_pkg;
  typedef enum logic [7:0] {
    OP_NONE  = 8'h00,
    OP_WRITE = 8'h02,
    OP_READ  = 8'h03,
    OP_RDST  = 8'h05,
    OP_LATCH = 8'h06
  } op_e;

  function automatic logic [7:0] status_byte(input logic busy, input logic wel);
    return {6'b0, wel, busy};
  endfunction
endpackage

// File: rtl/sme_edges.sv
module sme_edges #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;

  for (genvar g = 0; g < N; g++) begin : g_edge
    assign rise[g] = lvl[g] & ~prev_q[g];
    assign fall[g] = ~lvl[g] & prev_q[g];
  end
endmodule

// File: rtl/sme_shifter.sv
module sme_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       sample,
  input  logic       si,
  output logic       byte_done,
  output logic [7:0] byte_val,
  output logic [1:0] byte_idx,
  output logic       mid_byte
);
  logic [6:0] sh_q;
  logic [2:0] bit_q;

  assign byte_done = sample && (bit_q == 3'd7);
  assign byte_val  = {sh_q, si};
  assign mid_byte  = (bit_q != 3'd0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_q     <= '0;
      bit_q    <= '0;
      byte_idx <= '0;
    end else if (clear) begin
      bit_q    <= '0;
      byte_idx <= '0;
    end else if (sample) begin
      sh_q  <= byte_val[6:0];
      bit_q <= bit_q + 3'd1;
      if (byte_done && byte_idx != 2'd3) byte_idx <= byte_idx + 2'd1;
    end
endmodule

// File: rtl/sme_array.sv
module sme_array #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cell_q [DEPTH];

  assign rdata = cell_q[raddr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
    end else if (we) begin
      cell_q[waddr] <= wdata;
    end
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import sme_pkg::*;
#(
  parameter int AW        = 4,
  parameter int WR_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic wp_n,
  output logic so,
  output logic so_en,
  output logic busy,
  output logic standby
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);

  function automatic logic [AW-1:0] addr_next(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  // named internal events
  logic [1:0] rise, fall;
  logic sck_rise_w, sck_fall_w, cs_rise_w, cs_fall_w;
  logic active_w, mem_we_w, wren_ok_w, start_ok_w;
  logic byte_done, mid_byte;
  logic [7:0] byte_val, rd_data;
  logic [1:0] byte_idx;
  logic [AW-1:0] rd_addr;

  logic armed_q, wel_q, busy_q, wvld_q, abort_q, so_q;
  logic [7:0] cmd_q, wdata_q, out_sh, wr_data_q;
  logic [AW-1:0] addr_q, wr_addr_q;
  logic [CNT_W-1:0] cnt_q;

  sme_edges #(.N(2)) u_edges (
    .clk(clk), .rst_n(rst_n), .lvl({cs_n, sck}), .rise(rise), .fall(fall)
  );
  assign sck_rise_w = rise[0];
  assign sck_fall_w = fall[0];
  assign cs_rise_w  = rise[1];
  assign cs_fall_w  = fall[1];
  assign active_w   = armed_q & ~cs_n;

  sme_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .clear(cs_fall_w), .sample(sck_rise_w & active_w),
    .si(si), .byte_done(byte_done), .byte_val(byte_val), .byte_idx(byte_idx),
    .mid_byte(mid_byte)
  );

  assign rd_addr  = (byte_idx == 2'd1) ? byte_val[AW-1:0] : addr_q;
  assign mem_we_w = busy_q && (cnt_q == '0);

  sme_array #(.AW(AW)) u_array (
    .clk(clk), .rst_n(rst_n), .we(mem_we_w), .waddr(wr_addr_q), .wdata(wr_data_q),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign wren_ok_w  = (cmd_q == OP_LATCH) && (byte_idx == 2'd1) && !mid_byte;
  assign start_ok_w = (cmd_q == OP_WRITE) && wel_q && wvld_q && !mid_byte
                      && !abort_q && wp_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed_q <= 1'b0; wel_q <= 1'b0; busy_q <= 1'b0; wvld_q <= 1'b0;
      abort_q <= 1'b0; so_q <= 1'b0; cmd_q <= OP_NONE; wdata_q <= '0;
      out_sh <= '0; wr_data_q <= '0; addr_q <= '0; wr_addr_q <= '0; cnt_q <= '0;
    end else begin
      if (cs_fall_w) begin
        armed_q <= 1'b1;
        cmd_q   <= OP_NONE;
        wvld_q  <= 1'b0;
        abort_q <= 1'b0;
        so_q    <= 1'b0;
      end
      if (active_w && !wp_n) abort_q <= 1'b1;

      if (byte_done) begin
        if (byte_idx == 2'd0) begin
          cmd_q <= byte_val;
          if (byte_val == OP_RDST) out_sh <= status_byte(busy_q, wel_q);
        end else begin
          if (cmd_q == OP_RDST) out_sh <= status_byte(busy_q, wel_q);
          if (cmd_q == OP_READ) begin
            out_sh <= rd_data;
            addr_q <= addr_next(rd_addr);
          end else if (byte_idx == 2'd1) begin
            addr_q <= byte_val[AW-1:0];
          end
          if (byte_idx == 2'd2 && cmd_q == OP_WRITE && !wvld_q) begin
            wdata_q <= byte_val;
            wvld_q  <= 1'b1;
          end
        end
      end

      if (sck_fall_w && active_w) begin
        so_q   <= out_sh[7];
        out_sh <= {out_sh[6:0], 1'b0};
      end

      if (cs_rise_w && armed_q && !busy_q) begin
        if (wren_ok_w) wel_q <= 1'b1;
        if (start_ok_w) begin
          busy_q    <= 1'b1;
          cnt_q     <= CNT_W'(WR_CYCLES - 1);
          wr_addr_q <= addr_q;
          wr_data_q <= wdata_q;
        end
      end

      if (mem_we_w) begin
        busy_q <= 1'b0;
        wel_q  <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end

  assign so_en   = active_w;
  assign so      = active_w & so_q;
  assign busy    = busy_q;
  assign standby = cs_n & ~busy_q;
endmodule

// File: rtl/sme_checker.sv
module sme_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic wp_n,
  input logic so_en,
  input logic busy,
  input logic standby,
  input logic wel,
  input logic cs_rise,
  input logic mem_we
);
  assert_tristate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !so_en);
  assert_busy_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise));
  assert_store_in_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  assert_latch_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !wel);
  assert_wp_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !wp_n && !busy) |=> !busy);
  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_we) |=> busy);
  assert_standby_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !standby);
endmodule

bind spi_mem_slave sme_checker u_sme_checker (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .so_en(so_en),
  .busy(busy), .standby(standby), .wel(wel_q), .cs_rise(cs_rise_w),
  .mem_we(mem_we_w)
);

// File: tb/test_spi_mem_slave.sv
`timescale 1ns/1ps
module test_spi_mem_slave;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int WRC = 400;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, si, wp_n;
  logic so, so_en, busy, standby;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] rx;

  always #2.5 clk = ~clk;

  spi_mem_slave #(.AW(AW), .WR_CYCLES(WRC)) i_spi_mem_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n),
    .so(so), .so_en(so_en), .busy(busy), .standby(standby)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + 7) ^ 8'h5A);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] tx, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 0; i < n; i++) begin
      si = tx[7-i];
      ticks(HALF);
      r = {r[6:0], so};
      sck = 1'b1;
      ticks(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] r);
    spi_bits(tx, 8, r);
  endtask

  task automatic cs_low();
    @(negedge clk); cs_n = 1'b0; ticks(HALF);
  endtask

  task automatic cs_high();
    ticks(HALF); cs_n = 1'b1; ticks(HALF);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    ticks(2);
  endtask

  task automatic cmd_latch();
    logic [7:0] r;
    cs_low(); spi_byte(8'h06, r); cs_high();
  endtask

  task automatic send_write_open(input int a, input logic [7:0] d);
    logic [7:0] r;
    cs_low(); spi_byte(8'h02, r); spi_byte(8'(a), r); spi_byte(d, r);
  endtask

  task automatic read_byte(input int a, output logic [7:0] d);
    logic [7:0] r;
    cs_low(); spi_byte(8'h03, r); spi_byte(8'(a), r); spi_byte(8'h00, d); cs_high();
  endtask

  task automatic read_status(output logic [7:0] s);
    logic [7:0] r;
    cs_low(); spi_byte(8'h05, r); spi_byte(8'h00, s); cs_high();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, s;
    int cnt;
    rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; si = 1'b0; wp_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    ticks(5);
    rst_n = 1'b1;
    ticks(2);
    chk(so_en == 1'b0, "reset so_en", so_en, 0);
    chk(busy == 1'b0, "reset busy", busy, 0);
    chk(standby == 1'b0, "R11 standby with cs low", standby, 0);

    // R4: cs low since reset, traffic ignored
    spi_byte(8'h06, r);
    chk(so_en == 1'b0, "R4 unarmed so_en", so_en, 0);
    cs_n = 1'b1; ticks(HALF);
    chk(so_en == 1'b0, "R3 deselected so_en", so_en, 0);
    chk(standby == 1'b1, "R11 standby idle", standby, 1);
    read_status(s);
    chk(s == 8'h00, "R4 latch command before arming ignored", s, 0);

    // R5: write without latch
    send_write_open(3, 8'hAA); cs_high();
    chk(busy == 1'b0, "R5 busy without latch", busy, 0);
    read_byte(3, r);
    chk(r == model[3], "R5 memory unchanged", r, model[3]);

    // R1 R6 R9: sweep every address
    for (int a = 0; a < DEPTH; a++) begin
      cmd_latch();
      if (a == 0) begin
        read_status(s);
        chk(s == 8'h02, "R9 status after latch", s, 8'h02);
      end
      send_write_open(a, pat(a));
      ticks(HALF);
      @(negedge clk); cs_n = 1'b1;
      @(negedge clk);
      chk(busy == 1'b1, "R6 busy one clock after cs high", busy, 1);
      if (a == 0) begin
        cnt = 0;
        while (busy) begin cnt++; @(negedge clk); end
        chk(cnt == WRC, "R6 busy length", cnt, WRC);
      end else if (a == 1) begin
        chk(standby == 1'b0, "R11 standby while busy", standby, 0);
        read_status(s);
        chk(s == 8'h03, "R9 status during write", s, 8'h03);
      end
      wait_idle();
      model[a] = pat(a);
    end
    read_status(s);
    chk(s == 8'h00, "R6 latch cleared after write", s, 0);

    // R2: burst read of whole array, then wrap
    cs_low(); spi_byte(8'h03, r); spi_byte(8'h00, r);
    for (int a = 0; a < DEPTH; a++) begin
      spi_byte(8'h00, r);
      chk(r == model[a], "R1 R2 burst read", r, model[a]);
    end
    cs_high();
    cs_low(); spi_byte(8'h03, r); spi_byte(8'(DEPTH - 2), r);
    for (int k = 0; k < 4; k++) begin
      spi_byte(8'h00, r);
      chk(r == model[(DEPTH - 2 + k) % DEPTH], "R2 address wrap", r,
          model[(DEPTH - 2 + k) % DEPTH]);
    end
    cs_high();

    // R7: wp low during transfer
    cmd_latch();
    cs_low(); spi_byte(8'h02, r); spi_byte(8'd5, r);
    wp_n = 1'b0; spi_byte(8'hC3, r); wp_n = 1'b1;
    cs_high();
    chk(busy == 1'b0, "R7 cancelled busy", busy, 0);
    read_byte(5, r);
    chk(r == model[5], "R7 cancelled memory", r, model[5]);

    // R7: wp low in the same clock as cs high
    send_write_open(6, 8'h3C);
    ticks(HALF);
    @(negedge clk); cs_n = 1'b1; wp_n = 1'b0;
    @(negedge clk); wp_n = 1'b1;
    chk(busy == 1'b0, "R7 same-clock cancel", busy, 0);
    ticks(2);
    read_byte(6, r);
    chk(r == model[6], "R7 same-clock memory", r, model[6]);

    // R8: wp low one clock after commit
    send_write_open(7, 8'h96);
    ticks(HALF);
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); wp_n = 1'b0;
    chk(busy == 1'b1, "R8 busy despite wp", busy, 1);
    wait_idle(); wp_n = 1'b1;
    model[7] = 8'h96;
    read_byte(7, r);
    chk(r == model[7], "R8 write completed", r, model[7]);

    // R10: cs rises mid-byte
    cmd_latch();
    send_write_open(8, 8'h5A);
    spi_bits(8'hFF, 3, r);
    cs_high();
    chk(busy == 1'b0, "R10 no busy", busy, 0);
    read_byte(8, r);
    chk(r == model[8], "R10 memory unchanged", r, model[8]);

    // R13: two data bytes, latch still set from R10
    send_write_open(9, 8'h11); spi_byte(8'h22, r); cs_high();
    wait_idle();
    model[9] = 8'h11;
    read_byte(9, r);
    chk(r == model[9], "R13 first byte stored", r, model[9]);
    read_byte(10, r);
    chk(r == model[10], "R13 next address untouched", r, model[10]);

    // R12: commands during busy
    cmd_latch();
    send_write_open(11, 8'hE1); cs_high();
    chk(busy == 1'b1, "R12 first write busy", busy, 1);
    cmd_latch();
    send_write_open(12, 8'h7E); cs_high();
    wait_idle();
    model[11] = 8'hE1;
    read_byte(11, r);
    chk(r == model[11], "R12 first write stored", r, model[11]);
    read_byte(12, r);
    chk(r == model[12], "R12 write during busy ignored", r, model[12]);
    read_status(s);
    chk(s == 8'h00, "R12 latch during busy ignored", s, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule